// File: doc/BRIEF.md
# Flash Command Register Controller

This block is the synchronous command front end of a byte-wide, electrically erasable storage array. A host issues bus writes (address, data, active-low write strobe) and the block interprets them as commands. Some commands take effect on one write. Erase, program and reset each need a set-up write and a confirm write. After each command, later bus reads are served from one of four places: the array at the bus address, a pair of fixed identifier codes, the byte at a latched erase-verify address, or the byte at the latched program address.

Program and erase requests go to a small internal byte array whose depth is a parameter. Erase sweeps the array one byte per clock and sets every byte to FFh. Program waits a fixed number of cycles and then ANDs the new byte into the stored byte. A stop timer ends any operation that is still running after a parameterized number of cycles. A supply-enable input gates all modifying commands, and a registered flag reports whether that enable is present.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, and in the cycle after the supply enable `vpp_en` is seen low, the controller is in array-read mode with no operation running. `vpp_ok` equals `vpp_en` delayed by one clock.
- R2: A command write of 00h selects array read. Reads then return the byte stored at `bus_addr` until another command is written.
- R3: A command write of 90h selects identifier mode. A read at address 0 returns 89h, a read at address 1 returns BDh, and a read at any other address returns 00h.
- R4: Two consecutive writes of 20h start an erase. `busy` is high while the erase sweeps the array, and afterwards every byte reads FFh.
- R5: When the write after a 20h set-up write is not 20h, no erase starts, `busy` stays low, the array is unchanged and the controller returns to array read.
- R6: A write of 40h followed by one more write starts a program of the second write's address and data. `PROG_CYCLES` cycles later the stored byte becomes the old byte ANDed with the new data.
- R7: A write of A0h stops any running operation, latches the address of that write and enters erase verify. Reads then return the byte at the latched address, whatever `bus_addr` is.
- R8: A write of C0h stops any running operation and enters program verify. Reads then return the byte at the latched program address. A program stopped before it completes leaves its byte unchanged.
- R9: Two consecutive writes of FFh return the controller to array read.
- R10: While `vpp_en` is low, every bus write is ignored, reads return array data, and a running operation stops.
- R11: An operation that has run for `STOP_CYCLES` cycles ends. An erase cut short in this way has set only bytes 0 to `STOP_CYCLES`-1 to FFh.
- R12: The command address is taken in the cycle in which the strobe is seen to fall. The command data is taken in the cycle in which the strobe is seen to rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vpp_en | input | 1 | High-voltage supply enable |
| bus_addr | input | AW | Bus address, AW = log2(DEPTH) |
| bus_wdata | input | 8 | Bus write data |
| bus_we_n | input | 1 | Active-low write strobe |
| bus_rdata | output | 8 | Read data for the selected source |
| busy | output | 1 | Program or erase in progress |
| vpp_ok | output | 1 | Registered supply-enable status |

## Verification
The array is programmed at every address with a data pattern computed from the address. A second program of the same byte shows the AND behaviour, because a plain overwrite gives a different value. Each verify read uses a bus address that differs from the latched address, so the steering to the latched address can be told apart from a read at the bus address. The bench also covers a confirm write that is not 20h, a verify write that stops an erase or a program before it finishes, writes made while the supply enable is low, and a second instance with a short stop timer that shows an erase cut off partway through the array. During one program write the address changes while the strobe is low, which checks which address the controller captures.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
    typedef enum logic [3:0] {
        M_READ, M_IDENT, M_ERS_SETUP, M_ERS_RUN, M_ERS_VFY,
        M_PRG_SETUP, M_PRG_RUN, M_PRG_VFY, M_RST_SETUP
    } mode_e;

    typedef enum logic [1:0] { OP_NONE, OP_ERASE, OP_PROG } op_e;

    localparam logic [7:0] OPC_READ  = 8'h00;
    localparam logic [7:0] OPC_IDENT = 8'h90;
    localparam logic [7:0] OPC_ERASE = 8'h20;
    localparam logic [7:0] OPC_PROG  = 8'h40;
    localparam logic [7:0] OPC_EVFY  = 8'hA0;
    localparam logic [7:0] OPC_PVFY  = 8'hC0;
    localparam logic [7:0] OPC_RESET = 8'hFF;
    localparam logic [7:0] ID_MFR    = 8'h89;
    localparam logic [7:0] ID_DEV    = 8'hBD;
endpackage

// File: rtl/fcc_strobe_edge.sv
module fcc_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic we_n,
    output logic fall,
    output logic rise
);
    logic we_d, we_q;

    always_comb begin
        we_d = we_n;
        fall = we_q & ~we_n;
        rise = ~we_q & we_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) we_q <= 1'b1;
        else        we_q <= we_d;
    end
endmodule

// File: rtl/fcc_cmd_decode.sv
module fcc_cmd_decode #(
    parameter int AW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            vpp_en,
    input  logic            fall,
    input  logic            rise,
    input  logic [AW-1:0]   bus_addr,
    input  logic [7:0]      bus_wdata,
    output fcc_pkg::mode_e  mode,
    output logic [AW-1:0]   pgm_addr,
    output logic [7:0]      pgm_data,
    output logic [AW-1:0]   vfy_addr,
    output logic            start_erase,
    output logic            start_prog,
    output logic            abort
);
    import fcc_pkg::*;

    typedef struct packed {
        mode_e           mode;
        logic [AW-1:0]   addr_lat;
        logic [AW-1:0]   pgm_addr;
        logic [7:0]      pgm_data;
        logic [AW-1:0]   vfy_addr;
        logic            start_erase;
        logic            start_prog;
    } dec_t;

    dec_t d, q;

    always_comb begin
        d             = q;
        d.start_erase = 1'b0;
        d.start_prog  = 1'b0;
        abort         = 1'b0;
        if (fall) d.addr_lat = bus_addr;
        if (!vpp_en) begin
            d.mode = M_READ;
        end else if (rise) begin
            case (q.mode)
                M_PRG_SETUP: begin
                    d.pgm_addr   = q.addr_lat;
                    d.pgm_data   = bus_wdata;
                    d.start_prog = 1'b1;
                    d.mode       = M_PRG_RUN;
                end
                M_ERS_SETUP: begin
                    if (bus_wdata == OPC_ERASE) begin
                        d.start_erase = 1'b1;
                        d.mode        = M_ERS_RUN;
                    end else begin
                        d.mode = M_READ;
                    end
                end
                M_RST_SETUP: d.mode = M_READ;
                default: begin
                    case (bus_wdata)
                        OPC_IDENT: d.mode = M_IDENT;
                        OPC_ERASE: d.mode = M_ERS_SETUP;
                        OPC_PROG:  d.mode = M_PRG_SETUP;
                        OPC_RESET: d.mode = M_RST_SETUP;
                        OPC_EVFY: begin
                            d.mode     = M_ERS_VFY;
                            d.vfy_addr = q.addr_lat;
                            abort      = 1'b1;
                        end
                        OPC_PVFY: begin
                            d.mode = M_PRG_VFY;
                            abort  = 1'b1;
                        end
                        default:   d.mode = M_READ;
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.mode <= M_READ;
        end else begin
            q <= d;
        end
    end

    assign mode        = q.mode;
    assign pgm_addr    = q.pgm_addr;
    assign pgm_data    = q.pgm_data;
    assign vfy_addr    = q.vfy_addr;
    assign start_erase = q.start_erase;
    assign start_prog  = q.start_prog;
endmodule

// File: rtl/fcc_byte_array.sv
module fcc_byte_array #(
    parameter int DEPTH       = 16,
    parameter int PROG_CYCLES = 6,
    parameter int STOP_CYCLES = 40,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + PROG_CYCLES + STOP_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_erase,
    input  logic          start_prog,
    input  logic          stop,
    input  logic [AW-1:0] prog_addr,
    input  logic [7:0]    prog_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          busy
);
    import fcc_pkg::*;

    typedef struct packed {
        op_e           op;
        logic [CW-1:0] cnt;
    } ctl_t;

    ctl_t d, q;
    logic [7:0] mem [DEPTH];
    logic timer_hit, erase_last, prog_last, wr_erase, wr_prog;

    always_comb begin
        timer_hit  = (32'(q.cnt) == STOP_CYCLES - 1);
        erase_last = (32'(q.cnt) == DEPTH - 1);
        prog_last  = (32'(q.cnt) == PROG_CYCLES - 1);
        wr_erase   = !stop && (q.op == OP_ERASE);
        wr_prog    = !stop && (q.op == OP_PROG) && prog_last;
        d = q;
        if (stop) begin
            d.op = OP_NONE;
        end else if (start_erase) begin
            d.op  = OP_ERASE;
            d.cnt = '0;
        end else if (start_prog) begin
            d.op  = OP_PROG;
            d.cnt = '0;
        end else if (q.op != OP_NONE) begin
            if (timer_hit || (q.op == OP_ERASE && erase_last) ||
                (q.op == OP_PROG && prog_last))
                d.op = OP_NONE;
            else
                d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.op <= OP_NONE;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (wr_erase) begin
            mem[q.cnt[AW-1:0]] <= 8'hFF;
        end else if (wr_prog) begin
            mem[prog_addr] <= mem[prog_addr] & prog_data;
        end
    end

    assign rd_data = mem[rd_addr];
    assign busy    = (q.op != OP_NONE);
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
    parameter int DEPTH       = 16,
    parameter int PROG_CYCLES = 6,
    parameter int STOP_CYCLES = 40,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vpp_en,
    input  logic [AW-1:0] bus_addr,
    input  logic [7:0]    bus_wdata,
    input  logic          bus_we_n,
    output logic [7:0]    bus_rdata,
    output logic          busy,
    output logic          vpp_ok
);
    import fcc_pkg::*;

    logic          fall, rise, abort, stop, op_start;
    logic          start_erase, start_prog;
    mode_e         mode;
    logic [AW-1:0] pgm_addr, vfy_addr, rd_addr;
    logic [7:0]    pgm_data, arr_data, id_data;
    logic          vpp_d, vpp_q;

    fcc_strobe_edge i_edge (
        .clk(clk), .rst_n(rst_n), .we_n(bus_we_n), .fall(fall), .rise(rise)
    );

    fcc_cmd_decode #(.AW(AW)) i_dec (
        .clk(clk), .rst_n(rst_n), .vpp_en(vpp_en), .fall(fall), .rise(rise),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .mode(mode),
        .pgm_addr(pgm_addr), .pgm_data(pgm_data), .vfy_addr(vfy_addr),
        .start_erase(start_erase), .start_prog(start_prog), .abort(abort)
    );

    fcc_byte_array #(
        .DEPTH(DEPTH), .PROG_CYCLES(PROG_CYCLES), .STOP_CYCLES(STOP_CYCLES)
    ) i_arr (
        .clk(clk), .rst_n(rst_n), .start_erase(start_erase),
        .start_prog(start_prog), .stop(stop), .prog_addr(pgm_addr),
        .prog_data(pgm_data), .rd_addr(rd_addr), .rd_data(arr_data),
        .busy(busy)
    );

    always_comb begin
        stop     = abort | ~vpp_en;
        op_start = start_erase | start_prog;
        vpp_d    = vpp_en;
        case (mode)
            M_ERS_VFY: rd_addr = vfy_addr;
            M_PRG_VFY: rd_addr = pgm_addr;
            default:   rd_addr = bus_addr;
        endcase
        if (32'(bus_addr) == 0)      id_data = ID_MFR;
        else if (32'(bus_addr) == 1) id_data = ID_DEV;
        else                         id_data = 8'h00;
        bus_rdata = (mode == M_IDENT) ? id_data : arr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vpp_q <= 1'b0;
        else        vpp_q <= vpp_d;
    end

    assign vpp_ok = vpp_q;
endmodule

// File: rtl/fcc_checker.sv
module fcc_checker #(
    parameter int STOP_CYCLES = 40
) (
    input logic           clk,
    input logic           rst_n,
    input logic           vpp_en,
    input logic           bus_we_n,
    input logic           busy,
    input logic           vpp_ok,
    input logic           op_start,
    input fcc_pkg::mode_e mode
);
    import fcc_pkg::*;

    int run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        run_q <= 0;
        else if (op_start) run_q <= 0;
        else if (busy)     run_q <= run_q + 1;
        else               run_q <= 0;
    end

    AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < STOP_CYCLES));                              // R11
    AST_VPP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (vpp_ok == $past(vpp_en)));                          // R1
    AST_SAFE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !vpp_en |=> (mode == M_READ));                                // R1
    AST_LOWVPP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !vpp_en |=> !busy);                                           // R10
    AST_START_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_we_n));                             // R12
endmodule

bind flash_cmd_ctrl fcc_checker #(.STOP_CYCLES(STOP_CYCLES)) i_chk (
    .clk(clk), .rst_n(rst_n), .vpp_en(vpp_en), .bus_we_n(bus_we_n),
    .busy(busy), .vpp_ok(vpp_ok), .op_start(op_start), .mode(mode)
);

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;
    localparam int DEPTH = 16;
    localparam int AW    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vpp_en = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic bus_we_n = 1'b1;
    logic [7:0] bus_rdata, short_rdata;
    logic busy, vpp_ok, short_busy, short_vpp_ok;

    int checks = 0;
    int failures = 0;
    logic [7:0] model [DEPTH];

    always #4 clk = ~clk;

    flash_cmd_ctrl #(.DEPTH(DEPTH), .PROG_CYCLES(6), .STOP_CYCLES(40)) i_flash_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .vpp_en(vpp_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_we_n(bus_we_n), .bus_rdata(bus_rdata),
        .busy(busy), .vpp_ok(vpp_ok)
    );

    flash_cmd_ctrl #(.DEPTH(DEPTH), .PROG_CYCLES(6), .STOP_CYCLES(8)) i_short (
        .clk(clk), .rst_n(rst_n), .vpp_en(vpp_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_we_n(bus_we_n), .bus_rdata(short_rdata),
        .busy(short_busy), .vpp_ok(short_vpp_ok)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] dat);
        @(negedge clk);
        bus_addr = a; bus_wdata = dat; bus_we_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        bus_we_n = 1'b1;
        repeat (2) @(posedge clk);
    endtask

    // address moves while the strobe is low: the first value must be used (R12)
    task automatic wr_move(input logic [AW-1:0] a, input logic [7:0] dat);
        @(negedge clk);
        bus_addr = a; bus_wdata = dat; bus_we_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        bus_addr = ~a;
        @(posedge clk);
        @(negedge clk);
        bus_we_n = 1'b1;
        repeat (2) @(posedge clk);
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] v;
        idle(3);
        @(negedge clk) rst_n = 1'b1;
        idle(2);

        // R1: reset state
        @(negedge clk);
        check("R1 busy", {7'd0, busy}, 8'h00);
        check("R1 vpp_ok", {7'd0, vpp_ok}, 8'h01);
        rd(4'd2, v); check("R1 array read", v, 8'h00);

        // R3: identifier codes
        wr(4'd0, 8'h90);
        rd(4'd0, v); check("R3 mfr", v, 8'h89);
        rd(4'd1, v); check("R3 dev", v, 8'hBD);
        rd(4'd7, v); check("R3 other", v, 8'h00);

        // R4: full erase; R11: short timer instance
        wr(4'd0, 8'h20);
        wr(4'd0, 8'h20);
        @(negedge clk);
        check("R4 busy", {7'd0, busy}, 8'h01);
        idle(30);
        @(negedge clk);
        check("R4 done", {7'd0, busy}, 8'h00);
        wr(4'd0, 8'h00);
        for (int a = 0; a < DEPTH; a++) begin
            rd(AW'(a), v);
            check("R4 erased", v, 8'hFF);
            check("R11 timer cut", short_rdata, (a < 8) ? 8'hFF : 8'h00);
            model[a] = 8'hFF;
        end

        // R6/R8/R12: program every address, verify at latched address
        for (int a = 0; a < DEPTH; a++) begin
            logic [7:0] dat;
            dat = 8'((a * 29 + 7) & 8'hFF);
            wr(4'd0, 8'h40);
            wr_move(AW'(a), dat);
            idle(10);
            wr(4'd0, 8'hC0);
            model[a] = model[a] & dat;
            rd(AW'(~a), v);
            check("R8 verify", v, model[a]);
        end

        // R6: second program ANDs
        wr(4'd0, 8'h40);
        wr(4'd5, 8'h0F);
        idle(10);
        model[5] = model[5] & 8'h0F;

        // R2: array read sweep
        wr(4'd0, 8'h00);
        for (int a = 0; a < DEPTH; a++) begin
            rd(AW'(a), v);
            check("R2 R6 array", v, model[a]);
        end

        // R8: program stopped early leaves byte unchanged
        wr(4'd0, 8'h40);
        wr(4'd6, 8'h00);
        wr(4'd0, 8'hC0);
        @(negedge clk);
        check("R8 stopped", {7'd0, busy}, 8'h00);
        idle(10);
        rd(4'd0, v); check("R8 unchanged", v, model[6]);

        // R5: bad confirm
        wr(4'd0, 8'h20);
        wr(4'd0, 8'h55);
        @(negedge clk);
        check("R5 no busy", {7'd0, busy}, 8'h00);
        idle(25);
        for (int a = 0; a < DEPTH; a++) begin
            rd(AW'(a), v);
            check("R5 array", v, model[a]);
        end

        // R9: reset sequence leaves identifier mode
        wr(4'd0, 8'h90);
        wr(4'd0, 8'hFF);
        wr(4'd0, 8'hFF);
        rd(4'd0, v); check("R9 reset read", v, model[0]);

        // R10: supply low
        @(negedge clk) vpp_en = 1'b0;
        idle(2);
        @(negedge clk);
        check("R10 vpp_ok", {7'd0, vpp_ok}, 8'h00);
        wr(4'd0, 8'h20);
        wr(4'd0, 8'h20);
        @(negedge clk);
        check("R10 no erase", {7'd0, busy}, 8'h00);
        wr(4'd0, 8'h90);
        rd(4'd1, v); check("R10 no ident", v, model[1]);
        @(negedge clk) vpp_en = 1'b1;
        idle(2);
        @(negedge clk);
        check("R1 vpp_ok back", {7'd0, vpp_ok}, 8'h01);
        rd(4'd2, v); check("R10 read after", v, model[2]);

        // R7: erase verify stops erase early
        wr(4'd0, 8'h20);
        wr(4'd0, 8'h20);
        wr(4'd15, 8'hA0);
        @(negedge clk);
        check("R7 stopped", {7'd0, busy}, 8'h00);
        rd(4'd0, v); check("R7 verify", v, model[15]);

        // R7: full erase then verify
        wr(4'd0, 8'h20);
        wr(4'd0, 8'h20);
        idle(30);
        wr(4'd9, 8'hA0);
        rd(4'd0, v); check("R7 verify erased", v, 8'hFF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule